// File: doc/BRIEF.md
# Write-Commit Buffered Register Group

This block is a small register group whose software writes can be deferred. A CPU write port (enable, word address, data, byte strobes) feeds an address decoder. The decoder steers each write either straight into a plain register or into a holding stage that belongs to one buffered register. A holding stage keeps the written bytes and a per-byte pending mask. The register that hardware sees takes the new value only when that register's commit trigger fires. Wide values and groups of related values therefore change atomically from the point of view of the logic that consumes them.

Three trigger kinds are provided:
- A group of `NGRP` word registers commits when software writes the plain trigger register at word 0.
- A double-width register spread over two words commits when its upper word is written.
- A single word register commits on an external level with a configurable active polarity.

Triggers are ignored for a register that has nothing pending. A write that arrives in the same cycle as its commit is merged into the committed value. A per-register access strobe pulses in the cycle a commit takes effect.

Top module: `wcb_commit_regs`

## Requirements
- R1: A write to a buffered register (words 1..NGRP, NGRP+1, NGRP+2, NGRP+3) leaves that register's output unchanged until its commit trigger fires.
- R2: The double-width register (lower word at NGRP+1 = bits 31:0, upper word at NGRP+2 = bits 63:0's top half) commits both halves on the clock edge that ends any write to word NGRP+2, including a write whose byte strobes are all zero.
- R3: Word 0 is a plain register written directly with byte strobes. Any write to it commits every pending group register (words 1..NGRP) on the same edge.
- R4: The external trigger is active high when EXT_ACT_HIGH=1 and active low when it is 0. A pending value of the word NGRP+3 register appears on its output one cycle after the trigger is active.
- R5: A trigger event for a register with no pending bytes changes neither its output nor its access strobe.
- R6: At commit, only bytes whose strobe bit was set by a write since the last commit change; wr_strb bit k covers data bits 8k+7..8k.
- R7: wr_acc_o bit 0 (word 0), bits 1..NGRP (group), bit NGRP+1 (double-width) and bit NGRP+2 (external) are high only in the cycle whose closing edge commits that register (for bit 0: writes it). They are not high when a write only enters a holding stage.
- R8: After reset every output is zero and no bytes are pending.
- R9: A write to a register in the cycle its commit fires is merged into the committed value.
- R10: A write to a word address above NGRP+3 changes no output and raises no access strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | AW | Word address |
| wr_data | input | DW | Write data |
| wr_strb | input | DW/8 | Byte strobes |
| ext_trig | input | 1 | External commit trigger (polarity by EXT_ACT_HIGH) |
| trig_reg_o | output | DW | Plain register at word 0 |
| grp_regs_o | output | NGRP*DW | Group registers; register at word g+1 in bits g*DW upward |
| wide_reg_o | output | 2*DW | Double-width register |
| ext_reg_o | output | DW | Externally committed register |
| wr_acc_o | output | NGRP+3 | Per-register access strobes |

## Verification
The bench builds the block with DW=32, AW=4 and NGRP=3, so that words 7 to 15 are unmapped and the unmapped-address case can be reached. It also sets EXT_ACT_HIGH=0. With the trigger idling high, the inverted polarity path is exercised, and so is the case where holding the line at its inactive level must never commit. Three group registers let one trigger write show a commit of two pending registers and a skip of one idle register in the same cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int BYTE_W = 8;

    // Address of the plain trigger word
    localparam int TRIG_WORD = 0;
endpackage

// File: rtl/wcb_hold.sv
module wcb_hold #(
    parameter int NB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    wmask,
    input  logic [NB*8-1:0]  wdata,
    input  logic             trig,
    output logic [NB*8-1:0]  val_o,
    output logic             acc_o
);
    import wcb_pkg::*;

    typedef struct packed {
        logic [NB*8-1:0] hold;
        logic [NB*8-1:0] val;
        logic [NB-1:0]   pend;
    } st_t;

    st_t             s_d, s_q;
    logic [NB*8-1:0] hold_n;
    logic [NB-1:0]   pend_n;
    logic            fire;

    always_comb begin
        s_d    = s_q;
        hold_n = s_q.hold;
        pend_n = s_q.pend | wmask;
        for (int b = 0; b < NB; b++) begin
            if (wmask[b]) hold_n[b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
        end
        fire       = trig && (pend_n != '0);
        s_d.hold   = hold_n;
        s_d.pend   = pend_n;
        if (fire) begin
            for (int b = 0; b < NB; b++) begin
                if (pend_n[b]) s_d.val[b*BYTE_W +: BYTE_W] = hold_n[b*BYTE_W +: BYTE_W];
            end
            s_d.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign val_o = s_q.val;
    assign acc_o = fire;

    // R1: without a trigger the visible value never moves
    a_r1_held: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(val_o));
    // R5: trigger with nothing pending and nothing arriving is ignored
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && s_q.pend == '0 && wmask == '0) |=> $stable(val_o));
    // R7: strobe only alongside a trigger
    a_r7_acc: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> trig);
endmodule

// File: rtl/wcb_decode.sv
module wcb_decode #(
    parameter int DW   = 32,
    parameter int AW   = 4,
    parameter int NGRP = 3
) (
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW/8-1:0]      wr_strb,
    output logic [DW/8-1:0]      trig_mask,
    output logic                 grp_fire,
    output logic [NGRP*DW/8-1:0] grp_mask,
    output logic [DW/4-1:0]      wide_mask,
    output logic                 wide_fire,
    output logic [DW/8-1:0]      ext_mask
);
    localparam int NBW     = DW / 8;
    localparam int WIDE_LO = NGRP + 1;
    localparam int WIDE_HI = NGRP + 2;
    localparam int EXT_A   = NGRP + 3;

    logic hit_trig, hit_lo, hit_hi, hit_ext;

    always_comb begin
        hit_trig  = wr_en && (wr_addr == AW'(wcb_pkg::TRIG_WORD));
        hit_lo    = wr_en && (wr_addr == AW'(WIDE_LO));
        hit_hi    = wr_en && (wr_addr == AW'(WIDE_HI));
        hit_ext   = wr_en && (wr_addr == AW'(EXT_A));
        trig_mask = hit_trig ? wr_strb : '0;
        grp_fire  = hit_trig;
        wide_mask = {(hit_hi ? wr_strb : {NBW{1'b0}}), (hit_lo ? wr_strb : {NBW{1'b0}})};
        wide_fire = hit_hi;
        ext_mask  = hit_ext ? wr_strb : '0;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_mask[g*NBW +: NBW] =
            (wr_en && wr_addr == AW'(g + 1)) ? wr_strb : {NBW{1'b0}};
    end
endmodule

// File: rtl/wcb_commit_regs.sv
module wcb_commit_regs #(
    parameter int DW           = 32,
    parameter int AW           = 4,
    parameter int NGRP         = 3,
    parameter bit EXT_ACT_HIGH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW/8-1:0]    wr_strb,
    input  logic               ext_trig,
    output logic [DW-1:0]      trig_reg_o,
    output logic [NGRP*DW-1:0] grp_regs_o,
    output logic [2*DW-1:0]    wide_reg_o,
    output logic [DW-1:0]      ext_reg_o,
    output logic [NGRP+2:0]    wr_acc_o
);
    import wcb_pkg::*;

    localparam int NBW   = DW / 8;
    localparam int EXT_A = NGRP + 3;

    logic [NBW-1:0]      trig_mask, ext_mask;
    logic [NGRP*NBW-1:0] grp_mask;
    logic [2*NBW-1:0]    wide_mask;
    logic                grp_fire, wide_fire, ext_fire;
    logic [NGRP-1:0]     grp_acc;
    logic                wide_acc, ext_acc;

    wcb_decode #(.DW(DW), .AW(AW), .NGRP(NGRP)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb),
        .trig_mask(trig_mask), .grp_fire(grp_fire), .grp_mask(grp_mask),
        .wide_mask(wide_mask), .wide_fire(wide_fire), .ext_mask(ext_mask)
    );

    // Plain trigger register, written directly
    logic [DW-1:0] trig_d, trig_q;

    always_comb begin
        trig_d = trig_q;
        for (int b = 0; b < NBW; b++) begin
            if (trig_mask[b]) trig_d[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_d;
    end

    assign trig_reg_o = trig_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        wcb_hold #(.NB(NBW)) u_hold (
            .clk(clk), .rst_n(rst_n),
            .wmask(grp_mask[g*NBW +: NBW]), .wdata(wr_data), .trig(grp_fire),
            .val_o(grp_regs_o[g*DW +: DW]), .acc_o(grp_acc[g])
        );
    end

    wcb_hold #(.NB(2*NBW)) u_wide (
        .clk(clk), .rst_n(rst_n),
        .wmask(wide_mask), .wdata({wr_data, wr_data}), .trig(wide_fire),
        .val_o(wide_reg_o), .acc_o(wide_acc)
    );

    if (EXT_ACT_HIGH) begin : g_pol_hi
        assign ext_fire = ext_trig;
    end else begin : g_pol_lo
        assign ext_fire = ~ext_trig;
    end

    wcb_hold #(.NB(NBW)) u_ext (
        .clk(clk), .rst_n(rst_n),
        .wmask(ext_mask), .wdata(wr_data), .trig(ext_fire),
        .val_o(ext_reg_o), .acc_o(ext_acc)
    );

    assign wr_acc_o = {ext_acc, wide_acc, grp_acc, (trig_mask != '0)};

    // R10: unmapped words raise no strobe
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > AW'(EXT_A)) |-> (wr_acc_o == '0));
    // R3: group strobes only come from a write to the trigger word
    a_r3_group: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc_o[NGRP:1] != '0) |-> (wr_en && wr_addr == AW'(TRIG_WORD)));
endmodule

// File: tb/wcb_commit_regs_test.sv
module wcb_commit_regs_test;
    localparam int DW = 32, AW = 4, NGRP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [3:0]        wr_strb = '0;
    logic              ext_trig = 1'b1;
    logic [DW-1:0]     trig_reg_o, ext_reg_o;
    logic [NGRP*DW-1:0] grp_regs_o;
    logic [2*DW-1:0]   wide_reg_o;
    logic [NGRP+2:0]   wr_acc_o;
    logic [NGRP+2:0]   acc_seen;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wcb_commit_regs #(.DW(DW), .AW(AW), .NGRP(NGRP), .EXT_ACT_HIGH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .ext_trig(ext_trig),
        .trig_reg_o(trig_reg_o), .grp_regs_o(grp_regs_o), .wide_reg_o(wide_reg_o),
        .ext_reg_o(ext_reg_o), .wr_acc_o(wr_acc_o)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [2:0]  obs;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1, 32'h11111111, 4'hF, 3'd1, 64'h0},                  // R1
        '{1'b1, 4'd2, 32'h22222222, 4'h3, 3'd2, 64'h0},                  // R1
        '{1'b1, 4'd0, 32'hA5A5A5A5, 4'hF, 3'd0, 64'hA5A5A5A5},           // R3
        '{1'b0, 4'd0, 32'h0,        4'h0, 3'd1, 64'h11111111},           // R3
        '{1'b0, 4'd0, 32'h0,        4'h0, 3'd2, 64'h00002222},           // R6
        '{1'b0, 4'd0, 32'h0,        4'h0, 3'd3, 64'h0},                  // R5
        '{1'b1, 4'd4, 32'hDEADBEEF, 4'hF, 3'd4, 64'h0},                  // R1
        '{1'b1, 4'd5, 32'hCAFEF00D, 4'hF, 3'd4, 64'hCAFEF00D_DEADBEEF},  // R2
        '{1'b1, 4'd5, 32'h12345678, 4'h8, 3'd4, 64'h12FEF00D_DEADBEEF},  // R6
        '{1'b1, 4'd4, 32'h00000000, 4'hF, 3'd4, 64'h12FEF00D_DEADBEEF},  // R1
        '{1'b1, 4'd9, 32'hFFFFFFFF, 4'hF, 3'd0, 64'hA5A5A5A5},           // R10
        '{1'b1, 4'd0, 32'h0000005A, 4'h1, 3'd4, 64'h12FEF00D_DEADBEEF},  // R5
        '{1'b0, 4'd0, 32'h0,        4'h0, 3'd0, 64'hA5A5A55A},           // R3
        '{1'b1, 4'd5, 32'h00000000, 4'h0, 3'd4, 64'h12FEF00D_00000000}   // R2
    };

    localparam string VTAG [NV] = '{"R1","R1","R3","R3","R6","R5","R1",
                                    "R2","R6","R1","R10","R5","R3","R2"};

    function automatic logic [63:0] obs_val(input logic [2:0] sel);
        case (sel)
            3'd0:    return {32'h0, trig_reg_o};
            3'd1:    return {32'h0, grp_regs_o[31:0]};
            3'd2:    return {32'h0, grp_regs_o[63:32]};
            3'd3:    return {32'h0, grp_regs_o[95:64]};
            3'd4:    return wide_reg_o;
            default: return {32'h0, ext_reg_o};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle; acc_seen holds the strobes inside the cycle
    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic [3:0] s, input logic ext_on);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; wr_strb = s;
        ext_trig = ext_on ? 1'b0 : 1'b1;
        #5 acc_seen = wr_acc_o;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0; ext_trig = 1'b1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", {32'h0, trig_reg_o}, 64'h0);
        chk("R8", {32'h0, grp_regs_o[31:0]} | {32'h0, grp_regs_o[95:64]}, 64'h0);
        chk("R8", wide_reg_o, 64'h0);
        chk("R8", {58'h0, wr_acc_o}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].we, VECS[i].addr, VECS[i].data, VECS[i].strb, 1'b0);
            chk(VTAG[i], obs_val(VECS[i].obs), VECS[i].exp);
        end

        // R7: strobes during holding-stage write vs group commit
        cyc(1'b1, 4'd1, 32'h0BADF00D, 4'hF, 1'b0);
        chk("R7", {58'h0, acc_seen}, 64'h0);
        cyc(1'b1, 4'd3, 32'h33333333, 4'hF, 1'b0);
        chk("R1", {32'h0, grp_regs_o[95:64]}, 64'h0);
        cyc(1'b1, 4'd0, 32'h0, 4'h0, 1'b0);
        chk("R7", {58'h0, acc_seen}, 64'h0A);
        chk("R3", {grp_regs_o[95:64], grp_regs_o[31:0]}, 64'h33333333_0BADF00D);

        // R4: external register, active-low trigger
        cyc(1'b1, 4'd6, 32'h77777777, 4'hF, 1'b0);
        chk("R1", {32'h0, ext_reg_o}, 64'h0);
        cyc(1'b0, 4'd0, 32'h0, 4'h0, 1'b1);
        chk("R7", {63'h0, acc_seen[5]}, 64'h1);
        chk("R4", {32'h0, ext_reg_o}, 64'h77777777);
        // R5: trigger with nothing pending
        cyc(1'b0, 4'd0, 32'h0, 4'h0, 1'b1);
        chk("R5", {63'h0, acc_seen[5]}, 64'h0);
        chk("R5", {32'h0, ext_reg_o}, 64'h77777777);
        // R9: write merges into same-cycle commit
        cyc(1'b1, 4'd6, 32'h000000AB, 4'h1, 1'b1);
        chk("R9", {32'h0, ext_reg_o}, 64'h777777AB);
        // R10: unmapped write raises no strobe
        cyc(1'b1, 4'd12, 32'hFFFFFFFF, 4'hF, 1'b0);
        chk("R10", {58'h0, acc_seen}, 64'h0);
        chk("R10", {32'h0, ext_reg_o}, 64'h777777AB);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule